// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Counter

This block measures a fast clock against a slow one. It counts cycles of its own clock, the source clock, across a window of whole periods of a slower trigger clock, such as a 32.768 kHz reference. The trigger clock has no phase relation to the source clock. It is sampled through a flop synchronizer clocked by the source clock. Rising edges are then detected in the source domain, and they open and close the window.

Software or a sequencer pulses `start_i` with a period setting on `periods_i`. The setting is N minus 1, so the window spans N trigger periods. `busy_o` stays high while the block waits for the opening edge and while it counts. When the closing edge arrives, the count freezes on `count_o` and `done_o` rises. The source frequency then equals the count divided by the window time. That division is done outside this block. Because both window edges pass through the synchronizer, the result may differ from the ideal by up to two source cycles.

Top module: `freq_gate_counter`

## Requirements
- R1: While reset is asserted and directly after it is released, `busy_o` and `done_o` are 0 and `count_o` is 0.
- R2: A `start_i` pulse seen when the block is not busy (idle or done) takes effect in the next cycle. In that cycle `busy_o` is 1, `done_o` is 0 and `count_o` is 0.
- R3: The trigger input passes through a two-flop synchronizer in the source domain. Counting begins only at the first synchronized rising edge after the block is armed, so a window always starts and ends on a rising trigger edge.
- R4: A `periods_i` value of P gives a window of P+1 trigger periods. P = 0 gives one period and P = 31 gives 32 periods. The result is within ±2 of (P+1) × T_trig / T_src.
- R5: On the closing edge, `busy_o` falls, `done_o` rises and `count_o` freezes. `done_o` and `count_o` then stay unchanged until the next accepted start.
- R6: A `start_i` pulse while `busy_o` is 1 has no effect. The measurement in progress continues and its result is unchanged.
- R7: The count saturates at its all-ones value instead of wrapping to zero.
- R8: With the default 18-bit count, a window of about 78125 source cycles is reported correctly within ±2.
- R9: `periods_i` is captured when a start is accepted. Changes to it during a measurement do not alter the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source clock being measured; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized internally |
| trig_clk_i | input | 1 | Asynchronous slow trigger clock that sets the window |
| start_i | input | 1 | One-cycle request to begin a measurement |
| periods_i | input | PER_W (5) | Window length minus one, in trigger periods |
| busy_o | output | 1 | Measurement armed or in progress |
| done_o | output | 1 | Result valid; held until the next accepted start |
| count_o | output | CNT_W (18) | Source cycles counted in the window |

## Verification
A period counter that loads or decrements wrongly shows up as a result that is a whole multiple of the trigger period away from the ideal. That error appears once `done_o` rises, one trigger period early or late. A fault in the synchronizer or the edge detector moves the result outside the ±2 band, or the block never leaves the armed state, which the bench reports when its wait times out. A controller that leaks a start while busy would clear `count_o` in the cycle after the pulse, and the final result would fall well short of the ideal.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
  typedef enum logic [1:0] {
    FGC_IDLE = 2'd0,
    FGC_ARM  = 2'd1,
    FGC_RUN  = 2'd2,
    FGC_HOLD = 2'd3
  } fgc_state_e;
endpackage

// File: rtl/fgc_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module fgc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_n_o = rs_q[1];
endmodule

// File: rtl/fgc_edge_sync.sv
// Synchronizer chain plus one delay stage; flags a synchronized rising edge.
module fgc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] sh_q;
  logic [LEN-1:0] sh_d;

  generate
    if (LEN > 1) begin : g_chain
      always_comb sh_d = {sh_q[LEN-2:0], async_i};
    end else begin : g_single
      always_comb sh_d = async_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/fgc_ctrl.sv
// Measurement sequencer: arm, count over N trigger periods, hold result.
module fgc_ctrl
  import fgc_pkg::*;
#(
  parameter int PER_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PER_W-1:0] periods_i,
  input  logic             rise_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             clear_o,
  output logic             run_o
);
  fgc_state_e       st_q, st_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             per_en;
  logic             accept;

  assign accept = start_i && (st_q == FGC_IDLE || st_q == FGC_HOLD);

  always_comb begin
    st_d   = st_q;
    per_d  = per_q;
    per_en = 1'b0;
    unique case (st_q)
      FGC_IDLE, FGC_HOLD: begin
        if (accept) begin
          st_d   = FGC_ARM;
          per_d  = periods_i;
          per_en = 1'b1;
        end
      end
      FGC_ARM: begin
        if (rise_i) st_d = FGC_RUN;
      end
      FGC_RUN: begin
        if (rise_i) begin
          if (per_q == '0) begin
            st_d = FGC_HOLD;
          end else begin
            per_d  = per_q - PER_W'(1);
            per_en = 1'b1;
          end
        end
      end
      default: st_d = FGC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FGC_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      per_q <= '0;
    else if (per_en) per_q <= per_d;
  end

  assign busy_o  = (st_q == FGC_ARM) || (st_q == FGC_RUN);
  assign done_o  = (st_q == FGC_HOLD);
  assign clear_o = accept;
  assign run_o   = (st_q == FGC_RUN);
endmodule

// File: rtl/fgc_sat_counter.sv
// Clearable up-counter that stops at all ones.
module fgc_sat_counter #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clear_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (run_i && cnt_q != CNT_MAX) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter #(
  parameter int CNT_W       = 18,
  parameter int PER_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             src_clk,
  input  logic             rst_n,
  input  logic             trig_clk_i,
  input  logic             start_i,
  input  logic [PER_W-1:0] periods_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  logic rst_sync_n;
  logic trig_rise;
  logic clr;
  logic run;

  fgc_rst_sync u_rst (
    .clk     (src_clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  fgc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (src_clk),
    .rst_n   (rst_sync_n),
    .async_i (trig_clk_i),
    .rise_o  (trig_rise)
  );

  fgc_ctrl #(.PER_W(PER_W)) u_ctrl (
    .clk       (src_clk),
    .rst_n     (rst_sync_n),
    .start_i   (start_i),
    .periods_i (periods_i),
    .rise_i    (trig_rise),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .clear_o   (clr),
    .run_o     (run)
  );

  fgc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (src_clk),
    .rst_n   (rst_sync_n),
    .clear_i (clr),
    .run_i   (run),
    .count_o (count_o)
  );
endmodule

// File: rtl/fgc_checker.sv
module fgc_checker #(
  parameter int CNT_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] count
);
  // R5
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && count == '0));

  // R6
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && count != '0) |=> (count != '0));

  // R7
  count_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (count >= $past(count)));

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(count)));
endmodule

bind freq_gate_counter fgc_checker #(.CNT_W(CNT_W)) u_fgc_chk (
  .clk   (src_clk),
  .rst_n (rst_n),
  .start (start_i),
  .busy  (busy_o),
  .done  (done_o),
  .count (count_o)
);

// File: tb/freq_gate_counter_tb.sv
`timescale 1ns/1ps
module freq_gate_counter_tb;
  localparam real TCLK = 20.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  periods = 5'd0;
  logic        busy, done, s_busy, s_done;
  logic [17:0] count;
  logic [5:0]  s_count;
  real         trig_half = 1220.0;
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;

  freq_gate_counter u_dut (
    .src_clk(clk), .rst_n(rst_n), .trig_clk_i(trig), .start_i(start),
    .periods_i(periods), .busy_o(busy), .done_o(done), .count_o(count));

  freq_gate_counter #(.CNT_W(6)) u_sat (
    .src_clk(clk), .rst_n(rst_n), .trig_clk_i(trig), .start_i(start),
    .periods_i(periods), .busy_o(s_busy), .done_o(s_done), .count_o(s_count));

  always #(TCLK/2) clk = ~clk;
  initial forever begin #(trig_half); trig = ~trig; end
  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cyc >= 195000);
    fails++;
    $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cyc);
    summary();
  end

  task automatic chk(input string req, input int act, input int exp_lo, input int exp_hi);
    checks++;
    if (act < exp_lo || act > exp_hi) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=[%0d..%0d]", req, act, exp_lo, exp_hi);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 90000) begin @(negedge clk); n++; end
    chk(req, int'(done), 1, 1);
  endtask

  function automatic int ideal(input int p);
    return int'((p + 1) * 2.0 * trig_half / TCLK);
  endfunction

  task automatic run_measure(input string req, input int p, input real half);
    int id;
    trig_half = half;
    repeat (4) @(negedge clk);
    periods = 5'(p);
    pulse_start();
    // R2: next cycle busy, cleared, not done
    chk("R2 busy", int'(busy), 1, 1);
    chk("R2 done", int'(done), 0, 0);
    chk("R2 count", int'(count), 0, 0);
    wait_done(req);
    id = ideal(p);
    chk(req, int'(count), id - 2, id + 2);
    chk("R5 busy", int'(busy), 0, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    // R1
    chk("R1 busy", int'(busy), 0, 0);
    chk("R1 done", int'(done), 0, 0);
    chk("R1 count", int'(count), 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after release", int'(busy), 0, 0);
    chk("R1 count after release", int'(count), 0, 0);
  endtask

  task automatic t_one_period();
    run_measure("R3 R4 one period", 0, 1220.0);
    @(negedge clk);
    // R7: 6-bit instance saturates at 63
    chk("R7 saturate", int'(s_count), 63, 63);
  endtask

  task automatic t_ratios();
    run_measure("R4 32 periods", 31, 1220.0);
    run_measure("R4 5 periods", 4, 210.0);
    run_measure("R3 R4 odd ratio", 2, 617.3);
  endtask

  task automatic t_ignore();
    int id;
    trig_half = 1220.0;
    repeat (4) @(negedge clk);
    periods = 5'd3;
    pulse_start();
    repeat (150) @(negedge clk);
    periods = 5'd0;
    pulse_start();
    // R6
    chk("R6 busy kept", int'(busy), 1, 1);
    chk("R6 count kept", int'(count), 1, 1000);
    wait_done("R6 done");
    id = ideal(3);
    // R6 R9: original window of 4 periods
    chk("R6 R9 result", int'(count), id - 2, id + 2);
  endtask

  task automatic t_hold();
    int held = int'(count);
    repeat (300) @(negedge clk);
    // R5
    chk("R5 done held", int'(done), 1, 1);
    chk("R5 count held", int'(count), held, held);
  endtask

  task automatic t_wide();
    // R8: 32 periods of 2441.4 source cycles
    run_measure("R8 wide count", 31, 24414.0625);
  endtask

  initial begin
    t_reset();
    t_one_period();
    t_ratios();
    t_ignore();
    t_hold();
    t_wide();
    summary();
  end
endmodule